// File: doc/BRIEF.md
# Dual-Channel Serial DAC Input Interface

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. A host moves a word in one bit at a time on a serial data pin, timed by a serial clock and gated by an active-low select. When the word is complete, the host pulls one or both active-low load strobes low. Each strobe copies the shifted word into the holding register of its own channel, and that register is the code the converter sees.

The strobes act on level, not on an edge. While a strobe is low, its holding register is transparent and follows the shift register, so any bit shifted in during that time reaches the output. While a strobe is high, its register holds its value. An asynchronous active-low reset forces both holding registers to a value chosen by a select pin: all zeros when the pin is low, midscale when it is high. Reset does not clear the shift register.

Top module: `dual_dac_front`

## Requirements
- R1: The shift register takes the value of `sdi_i` on the rising edge of `clk_i`, and only while `cs_ni` is low.
- R2: Words are sent most significant bit first. After 12 clocks with `cs_ni` low, bit 11 of the shift register holds the first bit sent.
- R3: While `cs_ni` is high, rising edges of `clk_i` leave the shift register unchanged.
- R4: When more than 12 bits are sent, for example a 16-bit transfer made of two bytes, only the last 12 bits are kept. When fewer than 12 bits are sent, the older contents move up by that many places.
- R5: While `ld_a_ni` is low, `dac_a_o` takes the shift register value. While `ld_b_ni` is low, `dac_b_o` does the same. A channel whose strobe stays high keeps its value.
- R6: Pulling both strobes low together writes the same word to both channels.
- R7: The strobes are level-sensitive. Bits shifted in while a strobe is low show up on that channel's output after each clock edge.
- R8: While `rst_ni` is low and `mid_sel_i` is 0, both outputs read 0x000.
- R9: While `rst_ni` is low and `mid_sel_i` is 1, both outputs read 0x800 (bit 11 set, all other bits clear).
- R10: Reset overrides the strobes. The outputs keep the reset value even when a strobe is low.
- R11: Reset does not clear the shift register. A load made after reset is released returns the word that was shifted in before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Serial clock; data is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of both holding registers |
| cs_ni | input | 1 | Active-low select that enables shifting |
| sdi_i | input | 1 | Serial data, most significant bit first |
| ld_a_ni | input | 1 | Active-low level strobe for channel A |
| ld_b_ni | input | 1 | Active-low level strobe for channel B |
| mid_sel_i | input | 1 | Reset value select: 0 gives zero, 1 gives midscale |
| dac_a_o | output | 12 | Channel A holding register |
| dac_b_o | output | 12 | Channel B holding register |

## Verification
Two functions can act in the same cycle: shifting and a transparent load, and reset and a strobe load. To provoke the first case, the bench holds strobe A low while it clocks in a new word, then compares channel A with a partial word after four bits. It checks that channel B has not moved. To provoke the second case, the bench holds a strobe low while reset is asserted and expects the midscale value. After reset is released, it expects the word that was shifted in before the reset, which also shows that reset did not clear the shift register.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;
  localparam int unsigned DAC_W_DEF = 12;
  localparam int unsigned N_CH      = 2;
  typedef enum logic {RST_ZERO = 1'b0, RST_MID = 1'b1} rst_sel_e;
endpackage

// File: rtl/dac_shift_in.sv
module dac_shift_in #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         cs_ni,
  input  logic         sdi_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sr_q;

  // no reset: contents survive the holding-register reset
  always_ff @(posedge clk_i) begin
    if (!cs_ni) sr_q <= {sr_q[W-2:0], sdi_i};
  end

  assign word_o = sr_q;
endmodule

// File: rtl/dac_hold_reg.sv
module dac_hold_reg #(
  parameter int unsigned W = 12
) (
  input  logic         rst_ni,
  input  logic [W-1:0] rst_val_i,
  input  logic         ld_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // transparent while strobe low; reset dominates
  always_latch begin
    if (!rst_ni)     q_o <= rst_val_i;
    else if (!ld_ni) q_o <= d_i;
  end
endmodule

// File: rtl/dual_dac_front.sv
module dual_dac_front
  import dual_dac_pkg::*;
#(
  parameter int unsigned DAC_W = DAC_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sdi_i,
  input  logic             ld_a_ni,
  input  logic             ld_b_ni,
  input  logic             mid_sel_i,
  output logic [DAC_W-1:0] dac_a_o,
  output logic [DAC_W-1:0] dac_b_o
);
  localparam logic [DAC_W-1:0] MID_VAL = {1'b1, {(DAC_W-1){1'b0}}};

  logic [DAC_W-1:0] shift_w;
  logic [DAC_W-1:0] rst_val_w;
  logic [N_CH-1:0]  ld_n_w;
  logic [DAC_W-1:0] hold_w [N_CH];

  assign rst_val_w = (rst_sel_e'(mid_sel_i) == RST_MID) ? MID_VAL : '0;
  assign ld_n_w    = {ld_b_ni, ld_a_ni};

  dac_shift_in #(.W(DAC_W)) u_shift (
    .clk_i  (clk_i),
    .cs_ni  (cs_ni),
    .sdi_i  (sdi_i),
    .word_o (shift_w)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    dac_hold_reg #(.W(DAC_W)) u_hold (
      .rst_ni    (rst_ni),
      .rst_val_i (rst_val_w),
      .ld_ni     (ld_n_w[ch]),
      .d_i       (shift_w),
      .q_o       (hold_w[ch])
    );
  end

  assign dac_a_o = hold_w[0];
  assign dac_b_o = hold_w[1];
endmodule

// File: rtl/dual_dac_front_chk.sv
module dual_dac_front_chk #(
  parameter int unsigned DAC_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             sdi_i,
  input logic             ld_a_ni,
  input logic             ld_b_ni,
  input logic             mid_sel_i,
  input logic [DAC_W-1:0] shift_i,
  input logic [DAC_W-1:0] dac_a_o,
  input logic [DAC_W-1:0] dac_b_o
);
  localparam logic [DAC_W-1:0] MID_VAL = {1'b1, {(DAC_W-1){1'b0}}};

  // R1 R2
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !$isunknown(shift_i) && !$isunknown(sdi_i))
      |=> shift_i == {$past(shift_i[DAC_W-2:0]), $past(sdi_i)});

  // R3
  cs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && !$isunknown(shift_i)) |=> $stable(shift_i));

  // R5 R7
  transp_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_a_ni && !$isunknown(shift_i)) |-> dac_a_o == shift_i);

  // R5 R7
  transp_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_b_ni && !$isunknown(shift_i)) |-> dac_b_o == shift_i);

  // R8 R9 R10
  rst_val_a_chk: assert property (@(posedge clk_i)
    !rst_ni |-> dac_a_o == (mid_sel_i ? MID_VAL : '0));

  // R8 R9 R10
  rst_val_b_chk: assert property (@(posedge clk_i)
    !rst_ni |-> dac_b_o == (mid_sel_i ? MID_VAL : '0));
endmodule

bind dual_dac_front dual_dac_front_chk #(.DAC_W(DAC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .sdi_i     (sdi_i),
  .ld_a_ni   (ld_a_ni),
  .ld_b_ni   (ld_b_ni),
  .mid_sel_i (mid_sel_i),
  .shift_i   (shift_w),
  .dac_a_o   (dac_a_o),
  .dac_b_o   (dac_b_o)
);

// File: tb/dual_dac_front_test.sv
module dual_dac_front_test;
  logic        clk = 1'b0;
  logic        rst_n, cs_n, sdi, ld_a_n, ld_b_n, mid_sel;
  logic [11:0] dac_a, dac_b;
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;

  always #2 clk = ~clk;

  dual_dac_front uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cs_ni     (cs_n),
    .sdi_i     (sdi),
    .ld_a_ni   (ld_a_n),
    .ld_b_ni   (ld_b_n),
    .mid_sel_i (mid_sel),
    .dac_a_o   (dac_a),
    .dac_b_o   (dac_b)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  task automatic shift_word(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); cs_n = 1'b0; sdi = v[i];
    end
    @(negedge clk); cs_n = 1'b1; sdi = 1'b0;
  endtask

  task automatic strobe(input logic a, input logic b);
    @(negedge clk); ld_a_n = ~a; ld_b_n = ~b;
    @(negedge clk); ld_a_n = 1'b1; ld_b_n = 1'b1;
    #1;
  endtask

  task automatic t_reset_zero;
    #1;
    chk("R8 a", dac_a, 12'h000);
    chk("R8 b", dac_b, 12'h000);
  endtask

  task automatic t_reset_mid;
    @(negedge clk); mid_sel = 1'b1; rst_n = 1'b0;
    #1;
    chk("R9 a", dac_a, 12'h800);
    chk("R9 b", dac_b, 12'h800);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_word_a;
    shift_word(16'h0A5C, 12);
    strobe(1'b1, 1'b0);
    chk("R1 R2 R5 a", dac_a, 12'hA5C);
    chk("R5 b untouched", dac_b, 12'h800);
  endtask

  task automatic t_two_bytes;
    shift_word(16'hF123, 16);
    strobe(1'b0, 1'b1);
    chk("R4 16-bit b", dac_b, 12'h123);
    chk("R5 a held", dac_a, 12'hA5C);
  endtask

  task automatic t_partial;
    shift_word(16'h0007, 4);
    strobe(1'b1, 1'b0);
    chk("R4 partial a", dac_a, 12'h237);
  endtask

  task automatic t_cs_high;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sdi = i[0];
    end
    @(negedge clk); sdi = 1'b0;
    strobe(1'b0, 1'b1);
    chk("R3 cs high", dac_b, 12'h237);
  endtask

  task automatic t_both;
    shift_word(16'h03C3, 12);
    strobe(1'b1, 1'b1);
    chk("R6 a", dac_a, 12'h3C3);
    chk("R6 b", dac_b, 12'h3C3);
  endtask

  task automatic t_transparent;
    @(negedge clk); ld_a_n = 1'b0;
    for (int i = 11; i >= 8; i--) begin
      @(negedge clk); cs_n = 1'b0; sdi = 1'b0;
    end
    @(negedge clk); sdi = 1'b1;
    #1;
    chk("R7 mid-word a", dac_a, 12'hC30);
    for (int i = 6; i >= 0; i--) begin
      @(negedge clk); sdi = (i >= 4);
    end
    @(negedge clk); cs_n = 1'b1; sdi = 1'b0;
    #1;
    chk("R7 full word a", dac_a, 12'h0F0);
    chk("R7 b held", dac_b, 12'h3C3);
    @(negedge clk); ld_a_n = 1'b1;
  endtask

  task automatic t_rst_priority;
    @(negedge clk); ld_a_n = 1'b0; mid_sel = 1'b1; rst_n = 1'b0;
    #1;
    chk("R10 a", dac_a, 12'h800);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R11 a after release", dac_a, 12'h0F0);
    @(negedge clk); ld_a_n = 1'b1;
    strobe(1'b0, 1'b1);
    chk("R11 b", dac_b, 12'h0F0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 5000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sdi = 1'b0;
    ld_a_n = 1'b1; ld_b_n = 1'b1; mid_sel = 1'b0;
    @(negedge clk);
    t_reset_zero();
    @(negedge clk); rst_n = 1'b1;
    t_reset_mid();
    t_word_a();
    t_two_bytes();
    t_partial();
    t_cs_high();
    t_both();
    t_transparent();
    t_rst_priority();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule